// File: doc/BRIEF.md
# Configuration-Programmed Dual IO Window Decoder

The block keeps two 64-byte windows in IO address space. Each window's base address and enable flag are programmed through byte-enabled writes to fixed locations in a small configuration space. The same locations can be read back. For every IO address presented on its input, the block reports which window, if any, claims the address, and the offset of the address inside that window.

A configuration access carries a byte address whose two low bits are ignored. Four byte enables select the lanes of the addressed dword. A window's stored decode state is refreshed on any write that lands on its base dword or on its enable byte. The refreshed state takes effect at the same clock edge that updates the stored bytes. Address decode from `io_addr` to the hit and offset outputs is purely combinational. When both windows claim an address, window 0 takes priority.

Top module: `iowin_decoder`

## Requirements
- R1: Window 0 takes its base from the dword at configuration byte address 0x40, masked to bits [15:6]. An IO address hits window 0 (win_hit[0]) when window 0 is enabled and io_addr[15:6] equals those base bits.
- R2: Window 0 is enabled exactly when bit 0 of configuration byte 0x80 (dword 0x80, lane 0) is 1. While that bit is 0, win_hit[0] stays low.
- R3: Window 1 takes its base from the dword at 0x90, masked to bits [15:6]. Its enable is bit 0 of byte 0xD2 (dword 0xD0, lane 2). It reports on win_hit[1].
- R4: A write changes only the lanes whose byte enable is 1. Window decode reflects a write from the clock edge that accepts it. A write that touches neither a window's base dword nor its enable lane leaves that window's decode unchanged.
- R5: After reset, dword 0x40 reads 0x00000001, dword 0x80 reads 0, and window 0 never hits.
- R6: After reset, dword 0xD0 reads 0x00090000 and dword 0x90 reads the window 1 reset base with bit 0 set (default 0x00000B01). Window 1 is enabled at that base.
- R7: Bit 0 of bytes 0x40 and 0x90 ignores writes and always reads 1.
- R8: win_offset[6*i +: 6] equals io_addr[5:0] while win_hit[i] is 1, and is 0 otherwise.
- R9: When both windows match io_addr, only win_hit[0] is 1.
- R10: Configuration bytes other than the two base dwords and the two enable bytes read 0, and writes to them have no effect. A write with all byte enables 0 has no effect.
- R11: Bits [5:1] of a base dword's low byte, and its upper 16 bits, are stored and read back but do not take part in the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration write byte address (bits [1:0] ignored) |
| cfg_wr_be | input | 4 | Byte-lane enables for the write |
| cfg_wr_data | input | 32 | Write data, lane i in bits [8i+7:8i] |
| cfg_rd_addr | input | 8 | Configuration read byte address (bits [1:0] ignored) |
| cfg_rd_data | output | 32 | Combinational read data of the addressed dword |
| io_addr | input | 16 | IO address to decode |
| win_hit | output | 2 | Per-window hit flags, at most one set |
| win_offset | output | 12 | Per-window offset inside the window, 6 bits each |

## Verification
The hardest situation to produce is a partial write to an enable dword that leaves the enable lane unselected while the other lanes carry ones. A design that decodes enables without checking lanes would wrongly re-enable the window in that case. The stimulus first disables window 1, then writes all ones with enables 1011 to its enable dword, and then probes an address inside the window. Priority is exercised by pointing both bases at the same 64-byte block. Forced bit 0 and masked low bits are covered by writes that try to clear or set them, followed by readback and decode checks.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    localparam int CFG_AW      = 8;
    localparam int CFG_DWW     = CFG_AW - 2;
    localparam int DATA_W      = 32;
    localparam int LANES       = DATA_W / 8;
    localparam int IO_AW       = 16;
    localparam int OFF_W       = 6;
    localparam int BASE_W      = IO_AW - OFF_W;
    localparam int NUM_WIN     = 2;

    typedef logic [CFG_DWW-1:0] cfg_dw_t;

    typedef struct packed {
        logic                  en;
        cfg_dw_t               dw;
        logic [LANES-1:0]      be;
        logic [DATA_W-1:0]     data;
    } cfg_wr_t;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
    } win_dec_t;

    function automatic cfg_dw_t to_dw(input logic [CFG_AW-1:0] byte_addr);
        return byte_addr[CFG_AW-1:2];
    endfunction

    function automatic logic [7:0] lane_of(input logic [DATA_W-1:0] d, input int lane);
        return d[lane*8 +: 8];
    endfunction

endpackage

// File: rtl/iowin_cfg_slot.sv
module iowin_cfg_slot
    import iowin_pkg::*;
#(
    parameter cfg_dw_t     BASE_DW  = 6'h10,
    parameter cfg_dw_t     EN_DW    = 6'h20,
    parameter int          EN_LANE  = 0,
    parameter logic [15:0] RST_BASE = 16'h0000,
    parameter logic [7:0]  RST_EN   = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_wr_t           wr,
    input  cfg_dw_t           rd_dw,
    output logic [DATA_W-1:0] rd_data,
    output win_dec_t          dec
);

    localparam logic [DATA_W-1:0] RST_WORD = {16'h0000, RST_BASE} | 32'h1;

    logic [LANES-1:0][7:0] base_q, base_d;
    logic [7:0]            en_q, en_d;
    logic                  hit_base, hit_en, touched;
    logic [IO_AW-1:0]      base_full;

    assign hit_base = wr.en && (wr.dw == BASE_DW) && (|wr.be);
    assign hit_en   = wr.en && (wr.dw == EN_DW) && wr.be[EN_LANE];
    assign touched  = hit_base || hit_en;

    always_comb begin
        base_d = base_q;
        en_d   = en_q;
        if (hit_base) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr.be[i]) base_d[i] = lane_of(wr.data, i);
            end
        end
        base_d[0][0] = 1'b1;
        if (hit_en) en_d = lane_of(wr.data, EN_LANE);
    end

    assign base_full = {base_d[1], base_d[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= RST_WORD;
            en_q     <= RST_EN;
            dec.en   <= RST_EN[0];
            dec.base <= RST_BASE[IO_AW-1:OFF_W];
        end else begin
            base_q <= base_d;
            en_q   <= en_d;
            if (touched) begin
                dec.en   <= en_d[0];
                dec.base <= base_full[IO_AW-1:OFF_W];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_dw == BASE_DW)    rd_data = base_q;
        else if (rd_dw == EN_DW) rd_data[EN_LANE*8 +: 8] = en_q;
    end

    // R7: the read-only indicator bit is visible on every base read
    assert_base_bit0_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_dw == BASE_DW) |-> rd_data[0]);

    // R4: decode state holds unless a write lands on this window
    assert_dec_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !touched |=> $stable(dec));

    // R10: a write with no lanes enabled changes no stored byte
    assert_no_lane_R10: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.be == '0) |=> ($stable(base_q) && $stable(en_q)));

endmodule

// File: rtl/iowin_match.sv
module iowin_match
    import iowin_pkg::*;
(
    input  win_dec_t         dec,
    input  logic [IO_AW-1:0] io_addr,
    output logic             match,
    output logic [OFF_W-1:0] offset
);

    assign match  = dec.en && (io_addr[IO_AW-1:OFF_W] == dec.base);
    assign offset = io_addr[OFF_W-1:0];

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
    import iowin_pkg::*;
#(
    parameter logic [7:0]  W0_BASE_ADDR = 8'h40,
    parameter logic [7:0]  W0_EN_ADDR   = 8'h80,
    parameter logic [15:0] W0_RST_BASE  = 16'h0000,
    parameter logic [7:0]  W0_RST_EN    = 8'h00,
    parameter logic [7:0]  W1_BASE_ADDR = 8'h90,
    parameter logic [7:0]  W1_EN_ADDR   = 8'hD2,
    parameter logic [15:0] W1_RST_BASE  = 16'h0B00,
    parameter logic [7:0]  W1_RST_EN    = 8'h09
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr_en,
    input  logic [CFG_AW-1:0]        cfg_wr_addr,
    input  logic [LANES-1:0]         cfg_wr_be,
    input  logic [DATA_W-1:0]        cfg_wr_data,
    input  logic [CFG_AW-1:0]        cfg_rd_addr,
    output logic [DATA_W-1:0]        cfg_rd_data,
    input  logic [IO_AW-1:0]         io_addr,
    output logic [NUM_WIN-1:0]       win_hit,
    output logic [NUM_WIN*OFF_W-1:0] win_offset
);

    localparam logic [NUM_WIN*CFG_AW-1:0] BASE_ADDRS = {W1_BASE_ADDR, W0_BASE_ADDR};
    localparam logic [NUM_WIN*CFG_AW-1:0] EN_ADDRS   = {W1_EN_ADDR,   W0_EN_ADDR};
    localparam logic [NUM_WIN*16-1:0]     RST_BASES  = {W1_RST_BASE,  W0_RST_BASE};
    localparam logic [NUM_WIN*8-1:0]      RST_ENS    = {W1_RST_EN,    W0_RST_EN};

    cfg_wr_t              wr;
    cfg_dw_t              rd_dw;
    win_dec_t             dec    [NUM_WIN];
    logic [DATA_W-1:0]    slot_rd[NUM_WIN];
    logic [NUM_WIN-1:0]   match;
    logic [OFF_W-1:0]     raw_off[NUM_WIN];

    assign wr.en   = cfg_wr_en;
    assign wr.dw   = to_dw(cfg_wr_addr);
    assign wr.be   = cfg_wr_be;
    assign wr.data = cfg_wr_data;
    assign rd_dw   = to_dw(cfg_rd_addr);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [CFG_AW-1:0] EN_A = EN_ADDRS[g*CFG_AW +: CFG_AW];

        iowin_cfg_slot #(
            .BASE_DW  (to_dw(BASE_ADDRS[g*CFG_AW +: CFG_AW])),
            .EN_DW    (to_dw(EN_A)),
            .EN_LANE  (int'(EN_A[1:0])),
            .RST_BASE (RST_BASES[g*16 +: 16]),
            .RST_EN   (RST_ENS[g*8 +: 8])
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr),
            .rd_dw   (rd_dw),
            .rd_data (slot_rd[g]),
            .dec     (dec[g])
        );

        iowin_match u_match (
            .dec     (dec[g]),
            .io_addr (io_addr),
            .match   (match[g]),
            .offset  (raw_off[g])
        );

        // R8: offset is zero on a window that does not claim the address
        assert_off_idle_R8: assert property (@(posedge clk) disable iff (rst)
            !win_hit[g] |-> (win_offset[g*OFF_W +: OFF_W] == '0));
    end

    always_comb begin
        logic taken;
        taken       = 1'b0;
        win_hit     = '0;
        win_offset  = '0;
        cfg_rd_data = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (match[i] && !taken) begin
                win_hit[i]                    = 1'b1;
                win_offset[i*OFF_W +: OFF_W]  = raw_off[i];
                taken                         = 1'b1;
            end
            cfg_rd_data = cfg_rd_data | slot_rd[i];
        end
    end

    // R9: at most one window claims an address
    assert_single_hit_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_hit));

    // R9: window 0 wins whenever it matches
    assert_prio_R9: assert property (@(posedge clk) disable iff (rst)
        match[0] |-> (win_hit[0] && !win_hit[1]));

    // R2: a disabled window 0 never claims an address
    assert_w0_gated_R2: assert property (@(posedge clk) disable iff (rst)
        !dec[0].en |-> !win_hit[0]);

endmodule

// File: tb/iowin_decoder_bench.sv
module iowin_decoder_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [7:0]  cfg_wr_addr;
    logic [3:0]  cfg_wr_be;
    logic [31:0] cfg_wr_data;
    logic [7:0]  cfg_rd_addr;
    logic [31:0] cfg_rd_data;
    logic [15:0] io_addr;
    logic [1:0]  win_hit;
    logic [11:0] win_offset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    iowin_decoder u_iowin_decoder (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .io_addr(io_addr), .win_hit(win_hit), .win_offset(win_offset)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [15:0] io;
        logic [1:0]  hit;
        logic [5:0]  o0;
        logic [5:0]  o1;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h80, 4'h0, 32'h000000FF, 16'h0000, 2'b00, 6'h00, 6'h00, 8'd10}, // R10 no lanes
        '{1'b1, 8'h80, 4'h1, 32'h00000001, 16'h0005, 2'b01, 6'h05, 6'h00, 8'd2},  // R2 enable w0
        '{1'b1, 8'h40, 4'h3, 32'h00001240, 16'h1267, 2'b01, 6'h27, 6'h00, 8'd1},  // R1 base w0
        '{1'b0, 8'h00, 4'h0, 32'h00000000, 16'h1280, 2'b00, 6'h00, 6'h00, 8'd1},  // R1 miss
        '{1'b1, 8'h90, 4'h3, 32'h00001200, 16'h1210, 2'b10, 6'h00, 6'h10, 8'd3},  // R3 base w1
        '{1'b1, 8'h40, 4'h3, 32'h00001200, 16'h123F, 2'b01, 6'h3F, 6'h00, 8'd9},  // R9 overlap
        '{1'b1, 8'h80, 4'h1, 32'h00000000, 16'h1200, 2'b10, 6'h00, 6'h00, 8'd2},  // R2 disable w0
        '{1'b1, 8'hD0, 4'h4, 32'h00000000, 16'h1200, 2'b00, 6'h00, 6'h00, 8'd3},  // R3 disable w1
        '{1'b1, 8'hD0, 4'hB, 32'hFFFFFFFF, 16'h1200, 2'b00, 6'h00, 6'h00, 8'd4},  // R4 lane skipped
        '{1'b1, 8'hD0, 4'h4, 32'h00010000, 16'h1201, 2'b10, 6'h00, 6'h01, 8'd3},  // R3 enable w1
        '{1'b1, 8'h90, 4'h1, 32'h0000003E, 16'h1200, 2'b10, 6'h00, 6'h00, 8'd11}, // R11 masked bits
        '{1'b1, 8'h84, 4'hF, 32'hFFFFFFFF, 16'h1200, 2'b10, 6'h00, 6'h00, 8'd10}, // R10 other dword
        '{1'b1, 8'h40, 4'h2, 32'h00008000, 16'h8001, 2'b00, 6'h00, 6'h00, 8'd4},  // R4 partial base
        '{1'b1, 8'h80, 4'h1, 32'h00000001, 16'h8001, 2'b01, 6'h01, 6'h00, 8'd4}   // R4 enable after
    };

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = a;
        cfg_wr_be   = be;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic check_rd(input logic [7:0] a, input logic [31:0] exp, input int req);
        cfg_rd_addr = a;
        #1;
        checks++;
        if (cfg_rd_data !== exp) begin
            fails++;
            $display("FAIL R%0d read 0x%02h: actual 0x%08h expected 0x%08h", req, a, cfg_rd_data, exp);
        end
    endtask

    task automatic check_io(input logic [15:0] a, input logic [1:0] h,
                            input logic [5:0] o0, input logic [5:0] o1, input int req);
        io_addr = a;
        #1;
        checks++;
        if (win_hit !== h || win_offset !== {o1, o0}) begin
            fails++;
            $display("FAIL R%0d io 0x%04h: actual hit %b off 0x%03h expected hit %b off 0x%03h",
                     req, a, win_hit, win_offset, h, {o1, o0});
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_be = '0;
        cfg_wr_data = '0; cfg_rd_addr = '0; io_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5 / R6 reset state
        check_rd(8'h40, 32'h00000001, 5);
        check_rd(8'h80, 32'h00000000, 5);
        check_rd(8'hD0, 32'h00090000, 6);
        check_rd(8'h90, 32'h00000B01, 6);
        check_io(16'h0000, 2'b00, 6'h00, 6'h00, 5);
        check_io(16'h0B05, 2'b10, 6'h00, 6'h05, 6);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) cfg_write(VEC[i].addr, VEC[i].be, VEC[i].data);
            check_io(VEC[i].io, VEC[i].hit, VEC[i].o0, VEC[i].o1, int'(VEC[i].req));
        end

        // R4 / R7 / R11 readback of stored bytes
        check_rd(8'h40, 32'h00008001, 4);
        check_rd(8'h90, 32'h0000123F, 11);
        check_rd(8'h80, 32'h00000001, 2);
        check_rd(8'hD0, 32'h00010000, 3);

        // R7 bit 0 cannot be cleared
        cfg_write(8'h40, 4'hF, 32'hFFFFFFFE);
        check_rd(8'h40, 32'hFFFFFFFF, 7);
        cfg_write(8'h90, 4'h1, 32'h00000000);
        check_rd(8'h90, 32'h00001201, 7);

        // R10 neighbours of enable bytes stay zero
        cfg_write(8'h80, 4'hF, 32'hFFFFFFFF);
        check_rd(8'h80, 32'h000000FF, 10);
        cfg_write(8'hD0, 4'hF, 32'hFFFFFFFF);
        check_rd(8'hD0, 32'h00FF0000, 10);
        check_rd(8'h00, 32'h00000000, 10);

        // R1 top-of-space base, R8 offset
        check_io(16'hFFC5, 2'b01, 6'h05, 6'h00, 8);
        check_io(16'h1233, 2'b10, 6'h00, 6'h33, 8);

        // R5 reset again restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_rd(8'h40, 32'h00000001, 5);
        check_rd(8'h80, 32'h00000000, 5);
        check_rd(8'h90, 32'h00000B01, 6);
        check_io(16'hFFC5, 2'b00, 6'h00, 6'h00, 5);
        check_io(16'h0B3F, 2'b10, 6'h00, 6'h3F, 6);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule